// File: doc/BRIEF.md
# Carrier-Aligned Quadrature Position Tracker

This block turns the two phase signals of an incremental rotary encoder into a signed 32-bit step count and a rotor position. The position counts quadrature edges and wraps around at a programmable number of encoder lines per revolution. That line count is an ordinary integer, so values that are not powers of two, such as 12, give the correct wrap point. Both phase inputs are brought into the clock domain through a two-flop synchronizer before they are decoded.

A PWM modulator produces a one-cycle strobe at the peak and another at the valley of its triangle carrier. Either strobe copies the live count and position into a pair of snapshot registers. Control software reads the snapshots, so every sample it takes lines up with the switching period, however fast the shaft turns between two strobes. A small register port gives read access to the live and snapshot values, and write access to the line count.

Top module: `qenc_sync_top`

## Requirements
- R1: While `rst` is high, and on the first edge after it falls, the live count, live position, both snapshots and `rd_data` read 0, and the line count takes the value of the parameter `DEF_PPR`.
- R2: Each phase input passes through two flops. A level applied before rising edge k changes the live count at edge k+2, and a read of that count shows the change on `rd_data` after edge k+3.
- R3: With the phase pair written {A,B}, the forward order 00→10→11→01→00 adds one to the count per transition and the reverse order subtracts one. The count is a signed 32-bit two's-complement value.
- R4: A transition in which A and B change together changes neither the count nor the position, and an input pair that has not changed leaves both untouched.
- R5: The position counts edges from 0 to 4·PPR−1. A forward step from the top value goes to 0. When PPR is 0, the position stays at 0.
- R6: A reverse step from position 0 goes to 4·PPR−1.
- R7: A write with `wr_addr`=2 loads `wr_data` as the plain line count PPR and clears the position in the same edge, leaving the count unchanged. Writes to offsets 0, 1 and 3 change nothing.
- R8: On an edge where `carrier_peak` or `carrier_valley` is high, the step snapshot and the position snapshot load the live count and position held just before that edge.
- R9: On edges with neither strobe high, both snapshots keep their values, whatever the live values do.
- R10: `rd_data` is registered. After an edge it shows the value at the `rd_addr` sampled on that edge: offset 0 the live count, 1 the live position, 2 the step snapshot, 3 the position snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| carrier_peak | input | 1 | One-cycle strobe at the carrier maximum |
| carrier_valley | input | 1 | One-cycle strobe at the carrier minimum |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 2 | Register write word offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read word offset |
| rd_data | output | 32 | Registered read data |

## Verification
On every cycle, the assertions check the following:
- the forward and reverse step pulses never fire together;
- an idle decoder leaves the count untouched, and a forward pulse adds exactly one to it;
- the position never goes above its maximum;
- the snapshots load on a strobe and hold on every other edge.

Some behaviours only show at the ports when a complete sequence is driven, so the bench's scenarios cover them:
- the synchronizer latency;
- the wrap in each direction at a line count of 3 or 12;
- a change of line count that clears the position;
- negative counts;
- the full read map.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 2;
  localparam int OFS_CNT      = 0;
  localparam int OFS_POS      = 1;
  localparam int OFS_SNAP_CNT = 2;
  localparam int OFS_SNAP_POS = 3;
  localparam int OFS_PPR_WR   = 2;

  typedef enum logic [1:0] {
    STEP_NONE = 2'b00,
    STEP_FWD  = 2'b01,
    STEP_REV  = 2'b10
  } step_e;

  // Phase pair is {A,B}; forward order 00 -> 10 -> 11 -> 01 -> 00.
  function automatic step_e classify(input logic [1:0] prev, input logic [1:0] cur);
    unique case ({prev, cur})
      4'b00_10, 4'b10_11, 4'b11_01, 4'b01_00: classify = STEP_FWD;
      4'b00_01, 4'b01_11, 4'b11_10, 4'b10_00: classify = STEP_REV;
      default:                                 classify = STEP_NONE;
    endcase
  endfunction
endpackage

// File: rtl/qenc_sync2.sv
module qenc_sync2 #(
  parameter int WIDTH = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], async_in[b]};
    end
    assign sync_out[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/qenc_edge.sv
module qenc_edge
  import qenc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] ab_sync,
  output logic       step_up,
  output logic       step_dn
);
  logic [1:0] ab_prev;
  step_e      kind;

  always_ff @(posedge clk) begin
    if (rst) ab_prev <= 2'b00;
    else     ab_prev <= ab_sync;
  end

  always_comb begin
    kind    = classify(ab_prev, ab_sync);
    step_up = (kind == STEP_FWD);
    step_dn = (kind == STEP_REV);
  end
endmodule

// File: rtl/qenc_track.sv
module qenc_track #(
  parameter int CNT_W = 32,
  parameter int POS_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    step_up,
  input  logic                    step_dn,
  input  logic [POS_W-3:0]        ppr,
  input  logic                    ppr_load,
  output logic signed [CNT_W-1:0] count_q,
  output logic [POS_W-1:0]        pos_q,
  output logic [POS_W-1:0]        pos_max
);
  always_comb begin
    if (ppr == '0) pos_max = '0;
    else           pos_max = {ppr, 2'b00} - POS_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (step_up) begin
      count_q <= count_q + CNT_W'(1);
    end else if (step_dn) begin
      count_q <= count_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || ppr_load) begin
      pos_q <= '0;
    end else if (step_up) begin
      pos_q <= (pos_q >= pos_max) ? '0 : pos_q + POS_W'(1);
    end else if (step_dn) begin
      pos_q <= (pos_q == '0 || pos_q > pos_max) ? pos_max : pos_q - POS_W'(1);
    end
  end
endmodule

// File: rtl/qenc_snap.sv
module qenc_snap #(
  parameter int CNT_W = 32,
  parameter int POS_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    carrier_peak,
  input  logic                    carrier_valley,
  input  logic signed [CNT_W-1:0] count_live,
  input  logic [POS_W-1:0]        pos_live,
  output logic signed [CNT_W-1:0] count_snap,
  output logic [POS_W-1:0]        pos_snap
);
  logic capture;
  assign capture = carrier_peak | carrier_valley;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_snap <= '0;
      pos_snap   <= '0;
    end else if (capture) begin
      count_snap <= count_live;
      pos_snap   <= pos_live;
    end
  end
endmodule

// File: rtl/qenc_regmap.sv
module qenc_regmap
  import qenc_pkg::*;
#(
  parameter int POS_W   = 32,
  parameter int DEF_PPR = 1024
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  input  logic [DATA_W-1:0]  cnt_live,
  input  logic [DATA_W-1:0]  pos_live,
  input  logic [DATA_W-1:0]  cnt_snap,
  input  logic [DATA_W-1:0]  pos_snap,
  output logic [POS_W-3:0]   ppr_q,
  output logic               ppr_load,
  output logic [DATA_W-1:0]  rd_data
);
  assign ppr_load = wr_en && (wr_addr == ADDR_W'(OFS_PPR_WR));

  always_ff @(posedge clk) begin
    if (rst)           ppr_q <= (POS_W-2)'(DEF_PPR);
    else if (ppr_load) ppr_q <= wr_data[POS_W-3:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      unique case (rd_addr)
        ADDR_W'(OFS_CNT):      rd_data <= cnt_live;
        ADDR_W'(OFS_POS):      rd_data <= pos_live;
        ADDR_W'(OFS_SNAP_CNT): rd_data <= cnt_snap;
        default:               rd_data <= pos_snap;
      endcase
    end
  end
endmodule

// File: rtl/qenc_sync_top.sv
module qenc_sync_top
  import qenc_pkg::*;
#(
  parameter int DEF_PPR = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enc_a,
  input  logic              enc_b,
  input  logic              carrier_peak,
  input  logic              carrier_valley,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [1:0]        rd_addr,
  output logic [31:0]       rd_data
);
  localparam int CNT_W = DATA_W;
  localparam int POS_W = DATA_W;

  logic [1:0]              ab_sync;
  logic                    step_up, step_dn;
  logic [POS_W-3:0]        ppr_q;
  logic                    ppr_load;
  logic signed [CNT_W-1:0] count_q, count_snap;
  logic [POS_W-1:0]        pos_q, pos_max, pos_snap;

  qenc_sync2 #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .async_in({enc_a, enc_b}), .sync_out(ab_sync)
  );

  qenc_edge u_edge (
    .clk(clk), .rst(rst), .ab_sync(ab_sync), .step_up(step_up), .step_dn(step_dn)
  );

  qenc_track #(.CNT_W(CNT_W), .POS_W(POS_W)) u_track (
    .clk(clk), .rst(rst), .step_up(step_up), .step_dn(step_dn),
    .ppr(ppr_q), .ppr_load(ppr_load),
    .count_q(count_q), .pos_q(pos_q), .pos_max(pos_max)
  );

  qenc_snap #(.CNT_W(CNT_W), .POS_W(POS_W)) u_snap (
    .clk(clk), .rst(rst), .carrier_peak(carrier_peak), .carrier_valley(carrier_valley),
    .count_live(count_q), .pos_live(pos_q),
    .count_snap(count_snap), .pos_snap(pos_snap)
  );

  qenc_regmap #(.POS_W(POS_W), .DEF_PPR(DEF_PPR)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr),
    .cnt_live(count_q), .pos_live(pos_q), .cnt_snap(count_snap), .pos_snap(pos_snap),
    .ppr_q(ppr_q), .ppr_load(ppr_load), .rd_data(rd_data)
  );
endmodule

// File: rtl/qenc_sync_chk.sv
module qenc_sync_chk (
  input logic        clk,
  input logic        rst,
  input logic        peak,
  input logic        valley,
  input logic        up,
  input logic        dn,
  input logic [31:0] count,
  input logic [31:0] pos,
  input logic [31:0] pos_max,
  input logic [31:0] snap_cnt,
  input logic [31:0] snap_pos
);
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (count == 0 && pos == 0 && snap_cnt == 0 && snap_pos == 0)); // R1
  AST_STEP_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(up && dn)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!up && !dn) |=> $stable(count)); // R4
  AST_FWD_INC: assert property (@(posedge clk) disable iff (rst)
    up |=> count == $past(count) + 32'd1); // R3
  AST_POS_RANGE: assert property (@(posedge clk) disable iff (rst)
    pos <= pos_max); // R5
  AST_SNAP_LOAD: assert property (@(posedge clk) disable iff (rst)
    (peak || valley) |=> (snap_cnt == $past(count) && snap_pos == $past(pos))); // R8
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!peak && !valley) |=> ($stable(snap_cnt) && $stable(snap_pos))); // R9
endmodule

bind qenc_sync_top qenc_sync_chk u_chk (
  .clk(clk), .rst(rst), .peak(carrier_peak), .valley(carrier_valley),
  .up(step_up), .dn(step_dn), .count(count_q), .pos(pos_q), .pos_max(pos_max),
  .snap_cnt(count_snap), .snap_pos(pos_snap)
);

// File: tb/tb_qenc_sync_top.sv
`timescale 1ns/1ps
module tb_qenc_sync_top;
  localparam int DEF_PPR = 1024;

  logic clk = 0;
  logic rst;
  logic enc_a, enc_b, carrier_peak, carrier_valley, wr_en;
  logic [1:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;

  always #2.5 clk = ~clk;

  qenc_sync_top #(.DEF_PPR(DEF_PPR)) dut (
    .clk(clk), .rst(rst), .enc_a(enc_a), .enc_b(enc_b),
    .carrier_peak(carrier_peak), .carrier_valley(carrier_valley),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  int checks = 0, errors = 0;
  string tag = "R1";
  bit done = 0;

  // Behavioural reference model
  int          m_s1, m_s2, m_prev;   // phase pair as integer 0..3, {A,B}
  int          m_cnt, m_scnt;
  int unsigned m_pos, m_spos, m_ppr;
  logic [31:0] m_rd;

  function automatic int gray_idx(int ab);
    case (ab)
      0: return 0;   // 00
      2: return 1;   // 10
      3: return 2;   // 11
      default: return 3; // 01
    endcase
  endfunction

  function automatic int unsigned top_of(int unsigned p);
    return (p == 0) ? 0 : 4 * p - 1;
  endfunction

  always @(posedge clk) begin
    int          d, n_cnt;
    int unsigned n_pos, n_ppr;
    logic [31:0] n_rd;
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0;
      m_cnt = 0; m_scnt = 0; m_pos = 0; m_spos = 0; m_ppr = DEF_PPR; m_rd = 0;
    end else begin
      d = (gray_idx(m_s2) - gray_idx(m_prev) + 4) % 4;
      n_cnt = m_cnt; n_pos = m_pos; n_ppr = m_ppr;
      if (d == 1) begin
        n_cnt = m_cnt + 1;
        n_pos = (m_pos >= top_of(m_ppr)) ? 0 : m_pos + 1;
      end else if (d == 3) begin
        n_cnt = m_cnt - 1;
        n_pos = (m_pos == 0) ? top_of(m_ppr) : m_pos - 1;
      end
      if (wr_en && wr_addr == 2) begin
        n_ppr = wr_data & 32'h3FFF_FFFF;
        n_pos = 0;
      end
      case (rd_addr)
        2'd0: n_rd = m_cnt;
        2'd1: n_rd = m_pos;
        2'd2: n_rd = m_scnt;
        default: n_rd = m_spos;
      endcase
      if (carrier_peak || carrier_valley) begin
        m_scnt = m_cnt; m_spos = m_pos;
      end
      m_prev = m_s2; m_s2 = m_s1; m_s1 = {enc_a, enc_b};
      m_cnt = n_cnt; m_pos = n_pos; m_ppr = n_ppr; m_rd = n_rd;
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (rd_data !== m_rd) begin
        errors++;
        $display("FAIL %s/R10: rd_data actual %0h expected %0h", tag, rd_data, m_rd);
      end
    end
  end

  task automatic tick(input bit a, input bit b, input bit pk = 0, input bit vl = 0);
    @(negedge clk);
    enc_a = a; enc_b = b; carrier_peak = pk; carrier_valley = vl;
    wr_en = 0; rd_addr = rd_addr + 2'd1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] v);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = v; rd_addr = rd_addr + 2'd1;
    carrier_peak = 0; carrier_valley = 0;
    @(negedge clk);
    wr_en = 0;
  endtask

  // Forward: 00 -> 10 -> 11 -> 01 ; reverse is the opposite order
  int ph = 0;
  task automatic steps(input int n, input bit fwd, input int strobe_every = 0);
    for (int i = 0; i < n; i++) begin
      ph = fwd ? (ph + 1) % 4 : (ph + 3) % 4;
      case (ph)
        0: tick(0, 0, strobe_every != 0 && i % strobe_every == 0, 0);
        1: tick(1, 0, 0, strobe_every != 0 && i % strobe_every == 1);
        2: tick(1, 1, 0, 0);
        default: tick(0, 1, 0, 0);
      endcase
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(enc_a, enc_b);
  endtask

  initial begin
    rst = 1; enc_a = 0; enc_b = 0; carrier_peak = 0; carrier_valley = 0;
    wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
    repeat (3) @(negedge clk);
    tag = "R1";
    checks++;
    if (rd_data !== 32'd0) begin errors++; $display("FAIL R1: reset rd_data actual %0h expected 0", rd_data); end
    rst = 0;
    idle(6);

    tag = "R2"; steps(1, 1); idle(5);
    tag = "R3"; steps(9, 1); idle(4);
    tag = "R7"; wr(2'd2, 32'd3); wr(2'd0, 32'd77); wr(2'd1, 32'd5); wr(2'd3, 32'd9); idle(4);
    tag = "R5"; steps(14, 1); idle(4);
    tag = "R6"; steps(30, 0); idle(4);
    tag = "R4"; tick(1, 1); tick(0, 0); tick(1, 1); tick(0, 0); idle(5); ph = 0;
    tag = "R8"; steps(20, 1, 3); tick(enc_a, enc_b, 1, 0); idle(4); tick(enc_a, enc_b, 0, 1); idle(4);
    tag = "R9"; steps(25, 0); idle(8);
    tag = "R7"; wr(2'd2, 32'd12); steps(60, 1, 7); idle(4);
    tag = "R6"; steps(70, 0, 5); tick(enc_a, enc_b, 1, 0); idle(8);
    tag = "R5"; wr(2'd2, 32'd0); steps(8, 1); tick(enc_a, enc_b, 0, 1); idle(8);
    tag = "R10"; idle(12);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5ns * 200000);
    done = 1;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule